// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block turns parallel words into a serial bit stream, one bit per serial clock period, most significant bit first, and marks the start of every word with a frame sync pulse that it generates itself. It also produces the serial clock, dividing the system clock by a parameter. A per-word length field sets how many bits go out. A timing select places the sync either one bit period ahead of the first data bit (lead timing) or on the same period as that bit (aligned timing). An edge select chooses whether the outputs change on the rising or on the falling serial clock edge, so that a receiver sharing the clock can sample on the other edge.

Words arrive through a valid/ready load port and are only taken at a word boundary. With the back-to-back enable set and a long enough word, consecutive words run with no idle bit between them. In lead timing the sync for the next word then shares a bit period with the last bit of the current word. Timing, length and back-to-back settings are captured when a word starts from idle, and they stay fixed for the whole burst that follows.

Top module: `fser_tx`

## Requirements
- R1: While rst_n is low, sclk_o, sdo_o and fs_o are all 0.
- R2: sclk_o toggles once every HALF system clocks, starting at 0 after reset. sdo_o and fs_o change only in the system clock in which sclk_o goes to 1 (cfg_fall = 0) or to 0 (cfg_fall = 1). cfg_fall is captured only while the transmitter is idle.
- R3: Lead timing (cfg_late = 0): fs_o is 1 with sdo_o = 0 for one bit period, and the first data bit follows in the next bit period with fs_o = 0.
- R4: Aligned timing (cfg_late = 1): fs_o is 1 during the bit period that carries the first data bit and 0 for the remaining bits of the word.
- R5: A word carries cfg_len + 1 bits, in_data[cfg_len] first and down to in_data[0]. This holds for every cfg_len from 0 to W-1.
- R6: Back-to-back in lead timing (cfg_cont = 1, cfg_len >= 3): when a word is waiting, fs_o is 1 during the last bit of the current word, and the next word's first bit follows in the next bit period.
- R7: Back-to-back in aligned timing (cfg_cont = 1, cfg_len >= 3): when a word is waiting, the next word's first bit, with fs_o = 1, follows the last bit of the current word in the next bit period.
- R8: When cfg_len < 3, cfg_cont is ignored. At least one idle bit period with sdo_o = 0 and fs_o = 0 separates consecutive words.
- R9: In back-to-back mode, if no word is waiting at the boundary, the outputs go to 0. A later word then starts exactly as it would from idle.
- R10: cfg_late, cfg_len and cfg_cont are captured when a word is accepted from idle. Changes to them during a word or a burst have no effect on that word or burst.
- R11: in_ready is 1 only in a system clock in which the outputs may update, and only at an acceptance point. The acceptance points are: while idle; at the last-bit point in lead back-to-back mode; and when the last bit ends in aligned back-to-back mode. A word is taken when in_valid and in_ready are both 1 at a rising clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_late | input | 1 | 0 selects lead sync timing, 1 selects aligned sync timing |
| cfg_len | input | LW | Word length minus one |
| cfg_cont | input | 1 | Back-to-back enable |
| cfg_fall | input | 1 | 0: outputs change on rising sclk_o, 1: on falling sclk_o |
| in_valid | input | 1 | Load word present |
| in_data | input | W | Load word |
| in_ready | output | 1 | Word can be taken this clock |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data |
| fs_o | output | 1 | Frame sync |

## Verification
In lead back-to-back operation, three things happen in the same serial period: the last bit of one word goes out, the sync for the next word is raised, and the next word is taken from the load port. The bench provokes this by keeping in_valid high across several words with lengths of 4 and more. Its behavioural queue marks the final queued bit of the running word as carrying the sync at the moment of acceptance, and every clock it compares the DUT against that queue and against the expected in_ready. The aligned-timing counterpart is also covered, where acceptance and the first bit with sync coincide just after the last bit, as are short words where the back-to-back request must not take effect.

// File: rtl/fser_pkg.sv
package fser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_RUN  = 2'd2
    } tx_st_e;

endpackage

// File: rtl/fser_clkgen.sv
module fser_clkgen #(
    parameter int HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_fall,
    output logic sclk,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } gen_t;

    gen_t q, d;
    logic wrap;

    always_comb begin
        d    = q;
        wrap = (q.cnt == CW'(HALF - 1));
        if (wrap) begin
            d.cnt  = '0;
            d.sclk = ~q.sclk;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // the outputs update in the clock where sclk moves to the drive level
    assign tick = wrap && (q.sclk == drive_fall);
    assign sclk = q.sclk;

endmodule

// File: rtl/fser_core.sv
module fser_core
    import fser_pkg::*;
#(
    parameter int W  = 16,
    parameter int LW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cfg_late,
    input  logic [LW-1:0] cfg_len,
    input  logic          cfg_cont,
    input  logic          cfg_fall,
    input  logic          in_valid,
    input  logic [W-1:0]  in_data,
    output logic          in_ready,
    output logic          sdo,
    output logic          fs,
    output logic          drive_fall,
    output logic          idle,
    output logic [LW-1:0] cur_len,
    output logic          cur_late
);
    localparam int MIN_CONT = 3;

    typedef struct packed {
        tx_st_e        st;
        logic          late;
        logic [LW-1:0] len;
        logic          cont;
        logic          fall;
        logic          nxt;
        logic [LW-1:0] idx;
        logic [W-1:0]  hold;
        logic          sdo;
        logic          fs;
    } core_t;

    core_t q, d;
    logic  rdy;

    always_comb begin
        d   = q;
        rdy = 1'b0;
        if (q.st == ST_IDLE) d.fall = cfg_fall;
        case (q.st)
            ST_IDLE: begin
                rdy = tick;
                if (tick && in_valid) begin
                    d.late = cfg_late;
                    d.len  = cfg_len;
                    d.cont = cfg_cont && (int'(cfg_len) >= MIN_CONT);
                    d.hold = in_data;
                    d.nxt  = 1'b0;
                    d.fs   = 1'b1;
                    if (cfg_late) begin
                        d.sdo = in_data[cfg_len];
                        d.idx = cfg_len;
                        d.st  = ST_RUN;
                    end else begin
                        d.sdo = 1'b0;
                        d.st  = ST_LEAD;
                    end
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    d.sdo = q.hold[q.len];
                    d.fs  = 1'b0;
                    d.idx = q.len;
                    d.st  = ST_RUN;
                end
            end
            ST_RUN: begin
                if (q.idx != '0) begin
                    // lead timing: next word is taken as its sync joins the last bit
                    rdy = tick && q.cont && !q.late && (q.idx == LW'(1));
                    if (tick) begin
                        d.sdo = q.hold[q.idx - 1'b1];
                        d.idx = q.idx - 1'b1;
                        d.fs  = 1'b0;
                        if (rdy && in_valid) begin
                            d.fs   = 1'b1;
                            d.hold = in_data;
                            d.nxt  = 1'b1;
                        end
                    end
                end else begin
                    // aligned timing: next word is taken when the last bit ends
                    rdy = tick && q.cont && q.late;
                    if (tick) begin
                        if (q.nxt) begin
                            d.sdo = q.hold[q.len];
                            d.fs  = 1'b0;
                            d.idx = q.len;
                            d.nxt = 1'b0;
                        end else if (rdy && in_valid) begin
                            d.hold = in_data;
                            d.sdo  = in_data[q.len];
                            d.fs   = 1'b1;
                            d.idx  = q.len;
                        end else begin
                            d.sdo = 1'b0;
                            d.fs  = 1'b0;
                            d.st  = ST_IDLE;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready   = rdy;
    assign sdo        = q.sdo;
    assign fs         = q.fs;
    assign drive_fall = q.fall;
    assign idle       = (q.st == ST_IDLE);
    assign cur_len    = q.len;
    assign cur_late   = q.late;

endmodule

// File: rtl/fser_tx.sv
module fser_tx #(
    parameter int W    = 16,
    parameter int HALF = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_late,
    input  logic [$clog2(W)-1:0] cfg_len,
    input  logic                 cfg_cont,
    input  logic                 cfg_fall,
    input  logic                 in_valid,
    input  logic [W-1:0]         in_data,
    output logic                 in_ready,
    output logic                 sclk_o,
    output logic                 sdo_o,
    output logic                 fs_o
);
    localparam int LW = $clog2(W);

    logic          tick;
    logic          drive_fall;
    logic          core_idle;
    logic [LW-1:0] cur_len;
    logic          cur_late;

    fser_clkgen #(.HALF(HALF)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_fall (drive_fall),
        .sclk       (sclk_o),
        .tick       (tick)
    );

    fser_core #(.W(W), .LW(LW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cfg_late   (cfg_late),
        .cfg_len    (cfg_len),
        .cfg_cont   (cfg_cont),
        .cfg_fall   (cfg_fall),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .sdo        (sdo_o),
        .fs         (fs_o),
        .drive_fall (drive_fall),
        .idle       (core_idle),
        .cur_len    (cur_len),
        .cur_late   (cur_late)
    );

endmodule

// File: rtl/fser_tx_chk.sv
module fser_tx_chk #(
    parameter int HALF = 1,
    parameter int LW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sclk_o,
    input logic          sdo_o,
    input logic          fs_o,
    input logic          in_ready,
    input logic          core_idle,
    input logic [LW-1:0] cur_len,
    input logic          cur_late
);
    int fs_run;

    always_ff @(posedge clk) begin
        if (!rst_n)    fs_run <= 0;
        else if (fs_o) fs_run <= fs_run + 1;
        else           fs_run <= 0;
    end

    // R2: data and sync move only together with a serial clock transition
    a_r2_change_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((sdo_o != $past(sdo_o)) || (fs_o != $past(fs_o))) |-> (sclk_o != $past(sclk_o)));

    // R3: a sync pulse never lasts longer than one bit period
    a_r3_fs_one_period: assert property (@(posedge clk) disable iff (!rst_n)
        fs_run <= 2 * HALF);

    // R11: the load port opens only in a clock where the outputs may update
    a_r11_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (sclk_o != $past(sclk_o)));

    // R10: captured settings hold while a word or burst is running
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !core_idle |=> ($stable(cur_len) && $stable(cur_late)));

    // R9: when idle the serial lines rest low
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        core_idle |-> (!fs_o && !sdo_o));

endmodule

bind fser_tx fser_tx_chk #(.HALF(HALF), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_o    (sclk_o),
    .sdo_o     (sdo_o),
    .fs_o      (fs_o),
    .in_ready  (in_ready),
    .core_idle (core_idle),
    .cur_len   (cur_len),
    .cur_late  (cur_late)
);

// File: tb/fser_tx_test.sv
`timescale 1ns/1ps
module fser_tx_test;
    localparam int W  = 16;
    localparam int LW = $clog2(W);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_late, cfg_cont, cfg_fall, in_valid;
    logic [LW-1:0] cfg_len;
    logic [W-1:0]  in_data;
    logic          in_ready, sclk_o, sdo_o, fs_o;

    always #2.5 clk = ~clk;

    fser_tx #(.W(W), .HALF(1)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_late(cfg_late), .cfg_len(cfg_len),
        .cfg_cont(cfg_cont), .cfg_fall(cfg_fall), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .sclk_o(sclk_o),
        .sdo_o(sdo_o), .fs_o(fs_o)
    );

    int    checks = 0;
    int    errors = 0;
    string req    = "R1";
    bit    done   = 0;
    bit    took;

    typedef struct { bit fs; bit d; } pr_t;
    pr_t q_m[$];
    bit  sclk_m, fall_m, pop_m, late_m, cont_m, sdo_m, fs_m;
    int  len_m;

    task automatic chk(input string r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", r, what, act, exp, $time);
        end
    endtask

    task automatic push_word(input logic [W-1:0] dat, input bit lead, input bit ffs);
        pr_t e;
        if (lead) begin
            e.fs = 1; e.d = 0; q_m.push_back(e);
        end
        for (int i = len_m; i >= 0; i--) begin
            e.fs = (i == len_m) && ffs;
            e.d  = dat[i];
            q_m.push_back(e);
        end
    endtask

    // one system clock: predict, check ready, advance, check outputs
    task automatic cyc();
        bit  tk, rdy, acc, was_idle;
        pr_t e;
        #1;
        tk       = (sclk_m == fall_m);
        was_idle = (q_m.size() == 0) && !pop_m;
        rdy      = 0;
        if (tk) begin
            if (was_idle) rdy = 1;
            else if (q_m.size() == 0 && cont_m && late_m) rdy = 1;
            else if (q_m.size() == 1 && cont_m && !late_m) rdy = 1;
        end
        chk(req, "in_ready (R11)", in_ready, rdy);
        acc  = rdy && in_valid;
        took = acc;
        if (was_idle) fall_m = cfg_fall;
        if (acc) begin
            if (was_idle) begin
                late_m = cfg_late;
                len_m  = cfg_len;
                cont_m = cfg_cont && (cfg_len >= 3);
            end
            if (!late_m && q_m.size() == 1) begin
                e = q_m[0]; e.fs = 1; q_m[0] = e;
                push_word(in_data, 0, 0);
            end else if (late_m) begin
                push_word(in_data, 0, 1);
            end else begin
                push_word(in_data, 1, 0);
            end
        end
        if (tk) begin
            if (q_m.size() > 0) begin
                e = q_m.pop_front();
                sdo_m = e.d; fs_m = e.fs; pop_m = 1;
            end else begin
                sdo_m = 0; fs_m = 0; pop_m = 0;
            end
        end
        sclk_m = ~sclk_m;
        @(posedge clk);
        @(negedge clk);
        chk(req, "sclk_o", sclk_o, sclk_m);
        chk(req, "sdo_o", sdo_o, sdo_m);
        chk(req, "fs_o", fs_o, fs_m);
    endtask

    task automatic send(input logic [W-1:0] v);
        in_valid = 1; in_data = v;
        do cyc(); while (!took);
        in_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) cyc();
    endtask

    task automatic setc(input bit late, input int len, input bit cont, input bit fall);
        cfg_late = late; cfg_len = LW'(len); cfg_cont = cont; cfg_fall = fall;
    endtask

    initial begin
        rst_n = 0; in_valid = 0; in_data = '0;
        setc(0, 7, 0, 0);
        sclk_m = 0; fall_m = 0; pop_m = 0; late_m = 0; cont_m = 0;
        sdo_m = 0; fs_m = 0; len_m = 0;
        req = "R1";
        repeat (4) begin
            @(negedge clk);
            chk("R1", "reset sclk_o", sclk_o, 0);
            chk("R1", "reset sdo_o", sdo_o, 0);
            chk("R1", "reset fs_o", fs_o, 0);
        end
        rst_n = 1;
        idle(4);

        req = "R3"; setc(0, 7, 0, 0); send(16'h00A5); idle(20);
        req = "R4"; setc(1, 7, 0, 0); send(16'h003C); idle(20);
        req = "R6"; setc(0, 7, 1, 0);
        send(16'h0081); send(16'h007E); send(16'h00C3); idle(24);
        setc(0, 3, 1, 0); send(16'h0009); send(16'h0006); idle(16);
        req = "R7"; setc(1, 4, 1, 0);
        send(16'h0015); send(16'h000A); send(16'h001F); idle(20);
        req = "R8"; setc(0, 2, 1, 0);
        send(16'h0005); send(16'h0002); send(16'h0007); idle(16);
        setc(1, 2, 1, 0); send(16'h0003); send(16'h0004); idle(16);
        req = "R9"; setc(0, 5, 1, 0);
        send(16'h002A); idle(30); send(16'h0015); idle(20);
        setc(1, 3, 1, 0); send(16'h000B); idle(25); send(16'h0004); idle(16);
        req = "R2"; setc(0, 7, 0, 1); idle(6);
        send(16'h0096); idle(20);
        setc(1, 5, 1, 1); send(16'h0033); send(16'h0011); idle(20);
        setc(0, 7, 0, 0); idle(6);
        req = "R10"; setc(0, 7, 0, 0); send(16'h00E1);
        setc(1, 3, 1, 0); idle(24);
        setc(1, 4, 1, 0); send(16'h0012);
        setc(0, 9, 0, 0); in_valid = 1; in_data = 16'h0001;
        do cyc(); while (!took);
        in_valid = 0; idle(24);
        req = "R5"; setc(0, 0, 0, 0); send(16'h0001); idle(8);
        setc(1, 0, 1, 0); send(16'h0001); send(16'h0000); idle(8);
        setc(0, 15, 1, 0); send(16'hFFFF); send(16'h8001); idle(44);
        setc(1, 15, 0, 0); send(16'hA55A); idle(40);
        req = "R11"; setc(0, 7, 0, 0); send(16'h00F0); send(16'h000F); idle(24);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule